// File: doc/BRIEF.md
# Host Control Register Window

This block gives a host processor a byte-wide window onto an adapter's control registers. Each host access is a single-cycle strobe with a 9-bit address and an 8-bit data byte. The address carries three fields: the register index, the operation, and the area. Because the operation travels in the address, one host store can overwrite a register, AND a mask into it, or OR a mask into it. There is no separate read phase, so the update cannot be split by another agent. A fourth operation code reads a register.

The control area holds the following registers:
- a shared-memory relocation pair, which places the shared memory base on an 8 KB boundary and reports the strapped memory size;
- window base/open/close pairs;
- an adapter-side status pair;
- timer control and value pairs;
- a paging pair;
- the host interrupt status pair, which carries the interrupt enable.

Two identification areas return fixed bytes: the encoded node address and a computed test pattern. Any modifying access that has nowhere legal to land leaves all state as it was and raises an access flag. Timer, error and shared-memory-violation events also set status flags. A registered interrupt output combines the flags under the enable.

Top module: `ctl_window`

## Requirements
- R1: Address bits [4:0] select the register index, bits [6:5] select the operation (00 write, 01 AND, 10 OR, 11 read), and bits [8:7] select the area (00 control, 01 reserved, 10 identification A, 11 identification B). Read data appears on rdata_o one cycle after the read strobe and is held until the next read.
- R2: A write (op 00) to a legal control index replaces that register's writable bits with the data byte.
- R3: An AND (op 01) replaces the register with register AND data in the same single cycle.
- R4: An OR (op 10) replaces the register with register OR data in the same single cycle.
- R5: A read (op 11) changes no register, output or flag.
- R6: In control index 0x00, bits [7:1] drive sram_base_o[19:13]; sram_base_o[12:0] is always zero, and bit 0 reads as 0.
- R7: In control index 0x01, bits [3:2] always read back ram_size_i (00 = 8 KB, 01 = 16 KB, 10 = 32 KB, 11 = 64 KB), and host writes cannot alter them. Bits 7:4 and 1:0 are writable.
- R8: paging_en_o is high exactly when bits [7:6] of control index 0x18 are both 1, so writing 0xC0 turns paging on.
- R9: Area A index i returns byte i of NODE_ID (byte 0 = least significant) for i below ID_BYTES, and 0x00 otherwise. Area B index i returns 0xA5 XOR i.
- R10: A write, AND or OR to the reserved area, to either identification area, or to a control index in 0x10-0x17 or 0x1A-0x1F changes no register and sets bit 2 of the interrupt status register at control index 0x08. Reads of the reserved area or of those control indices return 0x00.
- R11: In control index 0x08:
  - tmr_evt_i sets bit 4;
  - err_evt_i sets bit 3;
  - sram_bad_i sets bit 2;
  - bit 6 is the interrupt enable;
  - an event wins over a host clear of the same bit in the same cycle.
- R12: irq_o equals, one cycle late, index 0x08 bit 6 AND the OR of index 0x08 bits [4:2] and index 0x09 bits [6:2]. With bit 6 clear, irq_o stays low.
- R13: After reset every register, rdata_o and irq_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe, one cycle per access |
| addr_i | input | 9 | {area, operation, index} |
| wdata_i | input | 8 | Data or mask byte |
| rdata_o | output | 8 | Read data, registered |
| tmr_evt_i | input | 1 | Timer expiry event |
| err_evt_i | input | 1 | Internal adapter error event |
| sram_bad_i | input | 1 | Illegal shared-memory access event |
| ram_size_i | input | 2 | Strapped shared memory size code |
| sram_base_o | output | 20 | Shared memory base address |
| paging_en_o | output | 1 | Shared memory paging enabled |
| irq_o | output | 1 | Host interrupt |

## Verification
A wrong register bit shows up on rdata_o at the read after the fault. For the relocation and paging registers it shows up on sram_base_o or paging_en_o in the cycle after the bad update. A stray or missing status flag moves irq_o exactly two cycles after the causing strobe or event, so the bench samples irq_o at both one and two cycles to catch both early and late output. Illegal modifying accesses are exposed by reading back the flag and the registers they could have hit.

// File: rtl/ctl_window_pkg.sv
`timescale 1ns/1ps
package ctl_window_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 5;
  localparam int NREG  = 1 << IDX_W;
  localparam int AW    = IDX_W + 4;

  typedef enum logic [1:0] {OP_WR = 2'b00, OP_AND = 2'b01, OP_OR = 2'b10, OP_RD = 2'b11} op_e;
  typedef enum logic [1:0] {AR_CTL = 2'b00, AR_RSV = 2'b01, AR_IDA = 2'b10, AR_IDB = 2'b11} area_e;

  localparam int IX_RELOC_E = 0;
  localparam int IX_RELOC_O = 1;
  localparam int IX_ISR_E   = 8;
  localparam int IX_ISR_O   = 9;
  localparam int IX_PAGE_E  = 24;
  localparam int IX_PAGE_O  = 25;

  function automatic logic idx_ok(input logic [IDX_W-1:0] i);
    return (i < IDX_W'(16)) || (i == IDX_W'(IX_PAGE_E)) || (i == IDX_W'(IX_PAGE_O));
  endfunction

  // host-modifiable bits per index
  function automatic logic [DW-1:0] wr_mask(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(IX_RELOC_E): return 8'hFE;
      IDX_W'(IX_RELOC_O): return 8'hF3;
      IDX_W'(IX_ISR_E):   return 8'h5D;
      IDX_W'(IX_ISR_O):   return 8'h7E;
      default:            return 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] apply_op(input op_e op, input logic [DW-1:0] cur,
                                             input logic [DW-1:0] d);
    case (op)
      OP_AND:  return cur & d;
      OP_OR:   return cur | d;
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/cwin_decode.sv
`timescale 1ns/1ps
module cwin_decode
  import ctl_window_pkg::*;
(
  input  logic              req_i,
  input  logic [AW-1:0]     addr_i,
  output op_e               op_o,
  output area_e             area_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              mod_en_o,
  output logic              bad_o,
  output logic              rd_en_o
);
  logic is_mod, legal;

  assign idx_o  = addr_i[IDX_W-1:0];
  assign op_o   = op_e'(addr_i[IDX_W+1:IDX_W]);
  assign area_o = area_e'(addr_i[IDX_W+3:IDX_W+2]);

  assign is_mod   = (op_o != OP_RD);
  assign legal    = (area_o == AR_CTL) && idx_ok(idx_o);
  assign mod_en_o = req_i && is_mod && legal;
  assign bad_o    = req_i && is_mod && !legal;
  assign rd_en_o  = req_i && !is_mod;
endmodule

// File: rtl/cwin_regs.sv
`timescale 1ns/1ps
module cwin_regs
  import ctl_window_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mod_en_i,
  input  op_e               op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              tmr_evt_i,
  input  logic              err_evt_i,
  input  logic              acc_set_i,
  input  logic [1:0]        size_i,
  output logic [DW-1:0]     rd_o,
  output logic [6:0]        base_o,
  output logic              paging_o,
  output logic              irq_en_o,
  output logic [2:0]        st_e_o,
  output logic [4:0]        st_o_o
);
  logic [NREG-1:0][DW-1:0] bank;
  logic [DW-1:0] set_e;

  assign set_e = {3'b000, tmr_evt_i, err_evt_i, acc_set_i, 2'b00};

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    localparam logic [IDX_W-1:0] KI = IDX_W'(k);
    if (idx_ok(KI)) begin : g_reg
      localparam logic [DW-1:0] M = wr_mask(KI);
      logic [DW-1:0] q, host_nx;
      logic hit;
      assign hit     = mod_en_i && (idx_i == KI);
      assign host_nx = hit ? ((q & ~M) | (apply_op(op_i, q, wdata_i) & M)) : q;
      if (k == IX_ISR_E) begin : g_isr
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q <= '0;
          else         q <= host_nx | set_e;   // events win over clears
      end else begin : g_plain
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q <= '0;
          else         q <= host_nx;
      end
      assign bank[k] = q;
    end else begin : g_hole
      assign bank[k] = '0;
    end
  end

  always_comb begin
    rd_o = bank[idx_i];
    if (idx_i == IDX_W'(IX_RELOC_O)) rd_o = rd_o | {4'b0000, size_i, 2'b00};
  end

  assign base_o   = bank[IX_RELOC_E][7:1];
  assign paging_o = &bank[IX_PAGE_E][7:6];
  assign irq_en_o = bank[IX_ISR_E][6];
  assign st_e_o   = bank[IX_ISR_E][4:2];
  assign st_o_o   = bank[IX_ISR_O][6:2];
endmodule

// File: rtl/cwin_id.sv
`timescale 1ns/1ps
module cwin_id
  import ctl_window_pkg::*;
#(
  parameter int               ID_BYTES = 6,
  parameter logic [8*ID_BYTES-1:0] NODE_ID = 48'h10005A123456,
  parameter logic [DW-1:0]    PAT_SEED = 8'hA5
) (
  input  logic              sel_b_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DW-1:0]     byte_o
);
  logic [DW-1:0] a_byte;

  always_comb begin
    a_byte = '0;
    for (int i = 0; i < ID_BYTES; i++)
      if (idx_i == IDX_W'(i)) a_byte = NODE_ID[8*i +: 8];
  end

  assign byte_o = sel_b_i ? (PAT_SEED ^ DW'(idx_i)) : a_byte;
endmodule

// File: rtl/cwin_irq.sv
`timescale 1ns/1ps
module cwin_irq #(
  parameter int NPEND = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [NPEND-1:0] pend_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= en_i && (|pend_i);
endmodule

// File: rtl/ctl_window.sv
`timescale 1ns/1ps
module ctl_window
  import ctl_window_pkg::*;
#(
  parameter int                    ID_BYTES = 6,
  parameter logic [8*ID_BYTES-1:0] NODE_ID  = 48'h10005A123456,
  parameter logic [7:0]            PAT_SEED = 8'hA5,
  parameter int                    BASE_LSB = 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic                  tmr_evt_i,
  input  logic                  err_evt_i,
  input  logic                  sram_bad_i,
  input  logic [1:0]            ram_size_i,
  output logic [BASE_LSB+6:0]   sram_base_o,
  output logic                  paging_en_o,
  output logic                  irq_o
);
  op_e              op;
  area_e            area;
  logic [IDX_W-1:0] idx;
  logic             mod_en, bad, rd_en;
  logic [DW-1:0]    ctl_rd, id_rd, rd_mux;
  logic [6:0]       base;
  logic             irq_en;
  logic [2:0]       st_e;
  logic [4:0]       st_o;

  cwin_decode u_dec (
    .req_i, .addr_i, .op_o(op), .area_o(area), .idx_o(idx),
    .mod_en_o(mod_en), .bad_o(bad), .rd_en_o(rd_en)
  );

  cwin_regs u_regs (
    .clk_i, .rst_ni, .mod_en_i(mod_en), .op_i(op), .idx_i(idx), .wdata_i,
    .tmr_evt_i, .err_evt_i, .acc_set_i(bad | sram_bad_i), .size_i(ram_size_i),
    .rd_o(ctl_rd), .base_o(base), .paging_o(paging_en_o),
    .irq_en_o(irq_en), .st_e_o(st_e), .st_o_o(st_o)
  );

  cwin_id #(.ID_BYTES(ID_BYTES), .NODE_ID(NODE_ID), .PAT_SEED(PAT_SEED)) u_id (
    .sel_b_i(area == AR_IDB), .idx_i(idx), .byte_o(id_rd)
  );

  cwin_irq #(.NPEND(8)) u_irq (
    .clk_i, .rst_ni, .en_i(irq_en), .pend_i({st_o, st_e}), .irq_o
  );

  always_comb
    case (area)
      AR_CTL:         rd_mux = ctl_rd;
      AR_IDA, AR_IDB: rd_mux = id_rd;
      default:        rd_mux = '0;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;

  assign sram_base_o = {base, {BASE_LSB{1'b0}}};
endmodule

// File: rtl/ctl_window_chk.sv
`timescale 1ns/1ps
module ctl_window_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [8:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        tmr_evt_i,
  input logic        err_evt_i,
  input logic        sram_bad_i,
  input logic [19:0] sram_base_o,
  input logic        paging_en_o,
  input logic        irq_o,
  input logic        irq_en,
  input logic [2:0]  st_e,
  input logic [4:0]  st_o
);
  assert_irq_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(irq_en) |-> !irq_o);

  assert_irq_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en && ((|st_e) || (|st_o))));

  assert_bad_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[6:5] != 2'b11 && addr_i[8:7] != 2'b00) |=> st_e[0]);

  assert_read_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[6:5] == 2'b11) |=> ($stable(sram_base_o) && $stable(paging_en_o)));

  assert_base_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_base_o[12:0] == 13'd0);

  assert_and_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == 9'h020) |=>
      ({sram_base_o[19:13], 1'b0} == ({$past(sram_base_o[19:13]), 1'b0} & $past(wdata_i))));

  assert_tmr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_i |=> st_e[2]);

  assert_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> st_e[1]);

  assert_sbad_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_bad_i |=> st_e[0]);
endmodule

bind ctl_window ctl_window_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .tmr_evt_i(tmr_evt_i), .err_evt_i(err_evt_i), .sram_bad_i(sram_bad_i),
  .sram_base_o(sram_base_o), .paging_en_o(paging_en_o), .irq_o(irq_o),
  .irq_en(irq_en), .st_e(st_e), .st_o(st_o)
);

// File: tb/ctl_window_bench.sv
`timescale 1ns/1ps
module ctl_window_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [8:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       tmr_evt_i = 1'b0, err_evt_i = 1'b0, sram_bad_i = 1'b0;
  logic [1:0] ram_size_i = 2'b10;
  logic [19:0] sram_base_o;
  logic       paging_en_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ctl_window u_ctl_window (.*);

  localparam logic [1:0] CTL = 2'b00, RSV = 2'b01, IDA = 2'b10, IDB = 2'b11;
  localparam logic [1:0] WR = 2'b00, ANDO = 2'b01, ORO = 2'b10, RD = 2'b11;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic acc(input logic [1:0] ar, input logic [1:0] op, input logic [4:0] ix,
                     input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; addr_i = {ar, op, ix}; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ar, input logic [4:0] ix, output logic [7:0] v);
    acc(ar, RD, ix, 8'h00);
    v = rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R13 irq", irq_o, 0);
    chk("R13 base", sram_base_o, 0);
    chk("R13 rdata", rdata_o, 0);
    rd(CTL, 5'h08, v); chk("R13 isr", v, 8'h00);
    rd(CTL, 5'h02, v); chk("R13 reg2", v, 8'h00);
  endtask

  task automatic t_ops;
    logic [7:0] v;
    acc(CTL, WR, 5'h00, 8'hFF);
    chk("R6 base after write", sram_base_o, 20'hFE000);
    rd(CTL, 5'h00, v); chk("R2 R6 reloc", v, 8'hFE);
    acc(CTL, ANDO, 5'h00, 8'h0F);
    chk("R3 base after and", sram_base_o, 20'h0E000);
    rd(CTL, 5'h00, v); chk("R3 reloc", v, 8'h0E);
    acc(CTL, WR, 5'h02, 8'h03);
    acc(CTL, ORO, 5'h02, 8'h30);
    rd(CTL, 5'h02, v); chk("R4 or", v, 8'h33);
    rd(CTL, 5'h02, v); chk("R5 second read", v, 8'h33);
    chk("R1 rdata held", rdata_o, 8'h33);
    chk("R5 base unchanged", sram_base_o, 20'h0E000);
  endtask

  task automatic t_size_paging;
    logic [7:0] v;
    acc(CTL, WR, 5'h01, 8'hFF);
    rd(CTL, 5'h01, v); chk("R7 size hi", v, 8'hFB);
    acc(CTL, WR, 5'h01, 8'h0C);
    rd(CTL, 5'h01, v); chk("R7 size only", v, 8'h08);
    acc(CTL, WR, 5'h18, 8'hC0);
    chk("R8 paging on", paging_en_o, 1);
    acc(CTL, ANDO, 5'h18, 8'h80);
    chk("R8 paging off", paging_en_o, 0);
  endtask

  task automatic t_ident;
    logic [7:0] v;
    rd(IDA, 5'd0, v); chk("R9 A0", v, 8'h56);
    rd(IDA, 5'd5, v); chk("R9 A5", v, 8'h10);
    rd(IDA, 5'd7, v); chk("R9 A7", v, 8'h00);
    rd(IDB, 5'd3, v); chk("R9 B3", v, 8'hA6);
    rd(IDB, 5'd0, v); chk("R9 B0", v, 8'hA5);
  endtask

  task automatic t_illegal;
    logic [7:0] v;
    acc(IDA, WR, 5'h02, 8'h00);
    rd(CTL, 5'h08, v); chk("R10 flag from id write", v, 8'h04);
    rd(CTL, 5'h02, v); chk("R10 reg2 untouched", v, 8'h33);
    chk("R12 gated irq", irq_o, 0);
    acc(CTL, ANDO, 5'h08, 8'h00);
    acc(CTL, WR, 5'h10, 8'hFF);
    rd(CTL, 5'h08, v); chk("R10 flag from hole", v, 8'h04);
    rd(CTL, 5'h10, v); chk("R10 hole reads 0", v, 8'h00);
    acc(CTL, ANDO, 5'h08, 8'h00);
    acc(RSV, ORO, 5'h00, 8'hFF);
    rd(CTL, 5'h08, v); chk("R10 flag from reserved", v, 8'h04);
    rd(CTL, 5'h00, v); chk("R10 reloc untouched", v, 8'h0E);
    rd(RSV, 5'h00, v); chk("R10 reserved reads 0", v, 8'h00);
    acc(CTL, ANDO, 5'h08, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    acc(CTL, ORO, 5'h08, 8'h40);
    @(negedge clk_i); chk("R12 enable no pend", irq_o, 0);
    // latency: event at edge N, irq at N+1
    tmr_evt_i = 1'b1; @(negedge clk_i); tmr_evt_i = 1'b0;
    chk("R12 not early", irq_o, 0);
    @(negedge clk_i); chk("R12 asserted", irq_o, 1);
    rd(CTL, 5'h08, v); chk("R11 timer bit", v, 8'h50);
    @(negedge clk_i);
    req_i = 1'b1; addr_i = {CTL, ANDO, 5'h08}; wdata_i = 8'h40; err_evt_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; err_evt_i = 1'b0;
    rd(CTL, 5'h08, v); chk("R11 event beats clear", v, 8'h48);
    acc(CTL, ANDO, 5'h08, 8'h40);
    chk("R12 still high one cycle", irq_o, 1);
    @(negedge clk_i); chk("R12 dropped", irq_o, 0);
    sram_bad_i = 1'b1; @(negedge clk_i); sram_bad_i = 1'b0;
    rd(CTL, 5'h08, v); chk("R11 sram bad bit", v, 8'h44);
    acc(CTL, ANDO, 5'h08, 8'h40);
    acc(CTL, ORO, 5'h09, 8'h20);
    @(negedge clk_i); chk("R12 odd source", irq_o, 1);
    acc(CTL, ANDO, 5'h08, 8'hBF);
    @(negedge clk_i); chk("R12 disable", irq_o, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ops();
    t_size_paging();
    t_ident();
    t_illegal();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule